// File: doc/BRIEF.md
# Self-Correcting Twisted-Ring Decade Counter

This block is a synchronous twisted-ring counter. Each enabled clock moves the ring one step. The next value of the first stage is the inverse of the last stage, and every other stage takes the value of the stage before it. The ring first fills with ones from the first stage onward and then empties from the first stage onward. With the default five stages it steps through ten states. With four stages it steps through eight. Each state drives exactly one decoded digit line, and every digit line is a single two-input gate on two neighbouring stages. The first and last stages count as neighbours for the two wrap states.

A ring with N stages has 2^N raw values, and only 2N of them lie on the counting cycle. The feedback logic tests whether the ring holds a legal pattern. A legal pattern has at most one boundary between ones and zeros along the stage chain. If the pattern is not legal, the next enabled step loads the all-zero state. The counter therefore settles on the legal cycle after power-up, whatever value the stages start with. A carry line is high for the first half of the cycle and low for the second half, so it gives one rising edge per full cycle for a following stage. A preload input writes a raw value into the ring. It exists so that every unused value can be planted and its recovery observed.

Top module: `jdc_counter`

## Requirements
- R1: A synchronous active-high `rst` sets all stages to 0 on the next clock edge. The result is digit 0 active and `carry` high. Reset has priority over `load` and `en`.
- R2: With `en` high and five stages, written as stage[0..4], the ring steps through 00000, 10000, 11000, 11100, 11110, 11111, 01111, 00111, 00011, 00001 and then returns to 00000. These are counts 0 to 9.
- R3: With `en` low and `load` low, the stage vector stays unchanged across clock edges.
- R4: From any legal state, an enabled step gives the next legal state of the R2 sequence, so the ring never leaves the legal cycle.
- R5: `digit[0]` is stage[0]=0 and stage[N-1]=0. `digit[N]` is stage[0]=1 and stage[N-1]=1. For k from 1 to N-1, `digit[k]` is stage[k-1]=1 and stage[k]=0, and `digit[N+k]` is stage[k-1]=0 and stage[k]=1. In every legal state exactly one digit line is high, and it is the line of the current count.
- R6: If the ring holds a pattern with more than one boundary between ones and zeros along stage[0..N-1], the next enabled clock loads all zeros. Every illegal value therefore reaches the legal cycle within N clocks.
- R7: `carry` is high while the count is 0 to N-1 and low while it is N to 2N-1. It rises only on the step from count 2N-1 to count 0.
- R8: With `load` high, the next clock writes `load_val` into the stages whatever the level of `en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to all zeros |
| en | input | 1 | Advance one step when high |
| load | input | 1 | Write `load_val` into the stages (test preload) |
| load_val | input | STAGES | Raw value to preload |
| stage | output | STAGES | Raw ring value, bit 0 is the first stage |
| digit | output | 2*STAGES | Decoded one-hot count lines |
| carry | output | 1 | High for the first half of the cycle |

## Verification
The assertions check the following on every cycle:
- the reset result;
- holding while enable is low;
- closure of the legal cycle;
- one-hot decoding in legal states;
- collapse of an illegal value to zero in one step;
- that `carry` only rises together with digit 0.

Only the bench scenarios can show the exact order of the ten states and that every line decodes to the right count. They also cover planting each of the 22 unused values through the preload and measuring the clocks to recovery, and the priority of preload over enable.

// File: rtl/jdc_pkg.sv
package jdc_pkg;

  localparam int MAX_STAGES = 16;

  // Number of places where two neighbouring stages differ (linear chain).
  function automatic int boundary_count(input logic [MAX_STAGES-1:0] s, input int n);
    int c;
    c = 0;
    for (int i = 1; i < MAX_STAGES; i++) begin
      if (i < n && s[i] != s[i-1]) c++;
    end
    return c;
  endfunction

  // A ring value is on the counting cycle when it has at most one boundary.
  function automatic logic ring_ok(input logic [MAX_STAGES-1:0] s, input int n);
    return boundary_count(s, n) <= 1;
  endfunction

endpackage

// File: rtl/jdc_ring.sv
module jdc_ring #(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [STAGES-1:0] load_val,
  output logic [STAGES-1:0] q,
  output logic              legal
);
  import jdc_pkg::*;

  logic [MAX_STAGES-1:0] padded;
  logic [STAGES-1:0]     twist_next;
  logic [STAGES-1:0]     step_next;

  always_comb begin
    padded = '0;
    padded[STAGES-1:0] = q;
    legal = ring_ok(padded, STAGES);
    twist_next = {q[STAGES-2:0], ~q[STAGES-1]};
    step_next  = legal ? twist_next : '0;
  end

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= load_val;
    else if (en)   q <= step_next;
  end

endmodule

// File: rtl/jdc_decode.sv
module jdc_decode #(
  parameter int STAGES = 5,
  localparam int DIGITS = 2 * STAGES
) (
  input  logic [STAGES-1:0] q,
  output logic [DIGITS-1:0] digit
);
  assign digit[0]      = ~q[0] & ~q[STAGES-1];
  assign digit[STAGES] =  q[0] &  q[STAGES-1];

  for (genvar k = 1; k < STAGES; k++) begin : g_pair
    assign digit[k]        =  q[k-1] & ~q[k];
    assign digit[STAGES+k] = ~q[k-1] &  q[k];
  end

endmodule

// File: rtl/jdc_counter.sv
module jdc_counter #(
  parameter int STAGES = 5,
  localparam int DIGITS = 2 * STAGES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              load,
  input  logic [STAGES-1:0] load_val,
  output logic [STAGES-1:0] stage,
  output logic [DIGITS-1:0] digit,
  output logic              carry
);
  logic ring_legal;

  jdc_ring #(.STAGES(STAGES)) u_ring (
    .clk(clk), .rst(rst), .en(en), .load(load), .load_val(load_val),
    .q(stage), .legal(ring_legal)
  );

  jdc_decode #(.STAGES(STAGES)) u_dec (
    .q(stage), .digit(digit)
  );

  assign carry = ~stage[STAGES-1];

endmodule

// File: rtl/jdc_checker.sv
module jdc_checker #(
  parameter int STAGES = 5,
  localparam int DIGITS = 2 * STAGES
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              load,
  input logic [STAGES-1:0] stage,
  input logic [DIGITS-1:0] digit,
  input logic              carry,
  input logic              state_legal
);
  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (stage == '0));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(stage));

  a_r4_stay_legal: assert property (@(posedge clk) disable iff (rst)
    (state_legal && en && !load) |=> state_legal);

  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    state_legal |-> ($countones(digit) == 1));

  a_r6_recover: assert property (@(posedge clk) disable iff (rst)
    (!state_legal && en && !load) |=> (stage == '0));

  a_r7_carry_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(carry) |-> digit[0]);

endmodule

bind jdc_counter jdc_checker #(.STAGES(STAGES)) u_chk (
  .clk(clk), .rst(rst), .en(en), .load(load), .stage(stage),
  .digit(digit), .carry(carry), .state_legal(ring_legal)
);

// File: tb/jdc_counter_tb.sv
module jdc_counter_tb;
  localparam int N = 5;
  localparam int D = 2 * N;

  // Legal cycle, written as bit string A..E (MSB = stage[0]).
  localparam logic [N-1:0] SEQ [D] = '{
    5'b00000, 5'b10000, 5'b11000, 5'b11100, 5'b11110,
    5'b11111, 5'b01111, 5'b00111, 5'b00011, 5'b00001
  };

  logic clk = 1'b0;
  logic rst = 1'b1, en = 1'b0, load = 1'b0;
  logic [N-1:0] load_val = '0;
  logic [N-1:0] stage;
  logic [D-1:0] digit;
  logic carry;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  jdc_counter #(.STAGES(N)) u_dut (
    .clk(clk), .rst(rst), .en(en), .load(load), .load_val(load_val),
    .stage(stage), .digit(digit), .carry(carry)
  );

  function automatic logic [N-1:0] as_stage(input logic [N-1:0] abcde);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = abcde[N-1-i];
    return r;
  endfunction

  function automatic int index_of(input logic [N-1:0] s);
    for (int i = 0; i < D; i++) if (as_stage(SEQ[i]) == s) return i;
    return -1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_count(input string req, input int idx);
    check(req, 32'(stage), 32'(as_stage(SEQ[idx])));
    check({req, "/R5 digit"}, 32'(digit), 32'(1) << idx);
    check({req, "/R7 carry"}, 32'(carry), 32'(idx < N));
  endtask

  initial begin
    int prev_carry, rises;
    @(negedge clk);
    tick();
    rst = 1'b0;
    // R1: reset state
    check_count("R1 reset", 0);

    // R2: walk the full table twice
    en = 1'b1;
    rises = 0;
    prev_carry = 1;
    for (int i = 0; i < 2 * D; i++) begin
      tick();
      check_count("R2 sequence", (i + 1) % D);
      if (carry && prev_carry == 0) rises++;
      prev_carry = int'(carry);
    end
    check("R7 one rise per cycle", 32'(rises), 32'd2);

    // R3: hold with enable low
    tick();
    en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tick();
      check("R3 hold", 32'(stage), 32'(as_stage(SEQ[1])));
    end

    // R4/R5: preload each legal state, check decode and next step
    for (int i = 0; i < D; i++) begin
      load = 1'b1; load_val = as_stage(SEQ[i]);
      tick();
      load = 1'b0;
      check_count("R5 decode", i);
      en = 1'b1;
      tick();
      en = 1'b0;
      check("R4 legal step", 32'(stage), 32'(as_stage(SEQ[(i + 1) % D])));
    end

    // R6/R8: plant every illegal value and measure recovery
    for (int v = 0; v < (1 << N); v++) begin
      if (index_of(N'(v)) < 0) begin
        int steps;
        load = 1'b1; load_val = N'(v);
        tick();
        load = 1'b0;
        check("R8 preload", 32'(stage), 32'(v));
        en = 1'b1;
        tick();
        check("R6 first step to zero", 32'(stage), 32'd0);
        steps = 1;
        while (index_of(stage) < 0 && steps <= N) begin
          tick();
          steps++;
        end
        en = 1'b0;
        check("R6 within bound", 32'(steps <= N), 32'd1);
      end
    end

    // R8: preload wins over enable
    en = 1'b1; load = 1'b1; load_val = as_stage(SEQ[6]);
    tick();
    load = 1'b0;
    check("R8 load over enable", 32'(stage), 32'(as_stage(SEQ[6])));

    // R1: reset mid-count wins over load and enable
    rst = 1'b1; load = 1'b1; load_val = 5'b10101;
    tick();
    rst = 1'b0; load = 1'b0; en = 1'b0;
    check_count("R1 reset priority", 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule